// File: doc/BRIEF.md
# Two-Input Buffered Frame Multiplexer

This block merges two streams of 64-bit frame beats onto a single output, one whole frame at a time. Neither input can be stalled, so each input writes into its own FIFO, and frames wait there until the output arbiter picks them. The output uses a valid/acknowledge handshake and marks each frame with a start flag, an end flag and a 3-bit count of valid bytes in the final beat. A count of 0 means that the final beat holds no valid bytes. Byte 0 of a beat sits in bits 7:0.

Each input has two options set at build time. The first is a prebuffer threshold. With a threshold of zero, a frame is released only after its last beat is stored (store-and-forward). With a threshold of N, the frame is released once N of its beats are stored (cut-through), which keeps a downstream transmitter from running dry. The second option removes the trailing 4-byte frame check sequence. The block then recomputes the final length and, when the last kept byte falls in the previous beat, moves the end flag back to that beat.

A frame that aborts on its input or overflows its FIFO before release is dropped whole. A cut-through frame that has already been released when the abort arrives is closed with an empty end beat that carries an error flag, so that a transmitter downstream can corrupt its check sequence.

Top module: `dual_frame_mux`

## Requirements
- R1: While reset is asserted and right after it is released, the output valid is low.
- R2: A frame leaves the output with its beats in input order and its data unchanged. Start is high on the first beat only and end on the last beat only. On an input that does not strip, the final length passes through unchanged, including 0, which means no valid bytes in that beat.
- R3: The output changes input only at a frame boundary and never interleaves beats of two frames. When both inputs have a frame ready, the input that did not send the previous frame goes next.
- R4: After an end beat is transferred, valid stays low for at least one cycle before the next start beat.
- R5: A beat transfers only on a cycle with valid and ack both high. While valid is high and ack is low, the data, flags and length hold. Once a frame starts, valid stays high until its end beat transfers, provided the cut-through input delivers a beat every cycle.
- R6: With a prebuffer threshold of 0 (input 0 by default), a frame starts on the output only after its end beat is stored. With a threshold of N (input 1 by default, N=2), a frame may start once N of its beats are stored, before its end beat arrives.
- R7: On a stripping input (input 1 by default), a final length L of 4 or more becomes L-4 in the same final beat. L=4 therefore gives an empty end beat.
- R8: On a stripping input, a final length L from 0 to 3 drops that final beat. The end flag moves to the previous beat with length (L+4) mod 8, so 0 becomes 4, 1 becomes 5, 2 becomes 6 and 3 becomes 7.
- R9: A frame that ends with the abort input before it is released never appears on the output. This applies to the cut-through input when fewer than N beats were stored.
- R10: Each input FIFO holds DEPTH/2 beats. A beat that arrives when at most one entry is free marks the frame as overflowed, and an overflowed unreleased frame never appears on the output. Later frames pass normally.
- R11: When the abort input arrives after a cut-through frame has been released, every stored beat is still sent, followed by one end beat with length 0 and the output error flag high. The error flag is low on every other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| in0Data | input | 64 | Input 0 beat data |
| in0Sof | input | 1 | Input 0 first beat of frame |
| in0Eof | input | 1 | Input 0 last beat of frame |
| in0Len | input | 3 | Input 0 valid bytes in last beat (0 = none) |
| in0Vld | input | 1 | Input 0 beat valid |
| in0Err | input | 1 | Input 0 frame abort |
| in1Data | input | 64 | Input 1 beat data |
| in1Sof | input | 1 | Input 1 first beat of frame |
| in1Eof | input | 1 | Input 1 last beat of frame |
| in1Len | input | 3 | Input 1 valid bytes in last beat (0 = none) |
| in1Vld | input | 1 | Input 1 beat valid |
| in1Err | input | 1 | Input 1 frame abort |
| outData | output | 64 | Output beat data |
| outSof | output | 1 | Output first beat of frame |
| outEof | output | 1 | Output last beat of frame |
| outLen | output | 3 | Output valid bytes in last beat |
| outErr | output | 1 | Output frame was cut short, on the end beat |
| outVld | output | 1 | Output beat valid |
| outAck | input | 1 | Downstream accepts the beat |

## Verification
Several faults in this block show up at the ports within a few cycles. A read, write or publish pointer that goes wrong in an input FIFO shows up as a missing, repeated or stale beat, or as a dropped frame that leaks out. An arbiter state that is wrong shows up as beats from both inputs mixed inside one frame, as a missing idle cycle after an end beat, or as the same input sent twice while the other one waits. A wrong length recomputation during stripping leaves the end flag on the wrong beat or an off-by-four count on the first end beat. Because the output is read straight from FIFO storage, each of these shows up at the ports in the cycle of the affected transfer.

// File: rtl/dfm_pkg.sv
package dfm_pkg;

  // One stored beat: payload plus the tags the reader needs.
  typedef struct packed {
    logic [63:0] data;
    logic        eof;
    logic [2:0]  len;
    logic        abort;
  } dfm_entry_t;

  // Strobes from the arbiter to the output datapath.
  typedef struct packed {
    logic busy;   // a frame is in progress on the output
    logic sel;    // input being forwarded
    logic first;  // next beat is the start beat
  } dfm_ctl_t;

endpackage

// File: rtl/dfm_infifo.sv
module dfm_infifo
  import dfm_pkg::*;
#(
  parameter int DEPTH_F = 16,
  parameter int DELAY   = 0,
  parameter bit STRIP   = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] inData,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [2:0]  inLen,
  input  logic        inVld,
  input  logic        inErr,
  input  logic        pop,
  output logic        avail,
  output dfm_entry_t  head
);
  localparam int AW  = $clog2(DEPTH_F);
  localparam int PW  = AW + 1;
  localparam int SAT = (DELAY > 0) ? DELAY : 1;
  localparam int CW  = $clog2(SAT + 1);

  dfm_entry_t mem [DEPTH_F];

  logic [PW-1:0] wrPtr, startPtr, pubPtr, rdPtr;
  logic [PW-1:0] wrNext, startNext, pubNext;
  logic          live, dropping, inFrame;
  logic          liveNext, dropNext, inFrameNext;
  logic [CW-1:0] fBeats, fBeatsNext;

  logic          wrEn;
  logic [AW-1:0] wrAddr;
  dfm_entry_t    wrEntry;

  logic [PW-1:0] count;
  logic          nearFull;
  logic          effDrop, effLive;
  logic [CW-1:0] effBeats, beatsInc;
  logic [PW-1:0] effStart;
  logic [AW-1:0] prevIdx;
  logic          goLive;

  assign count    = wrPtr - rdPtr;
  assign nearFull = count >= PW'(DEPTH_F - 1);
  assign effDrop  = inSof ? 1'b0 : dropping;
  assign effLive  = inSof ? 1'b0 : live;
  assign effBeats = inSof ? '0 : fBeats;
  assign effStart = inSof ? wrPtr : startPtr;
  assign prevIdx  = wrPtr[AW-1:0] - AW'(1);
  assign beatsInc = (effBeats == CW'(SAT)) ? effBeats : effBeats + CW'(1);
  assign goLive   = effLive || ((DELAY != 0) && (int'(beatsInc) >= DELAY));

  always_comb begin
    wrNext      = wrPtr;
    startNext   = startPtr;
    pubNext     = pubPtr;
    liveNext    = live;
    dropNext    = dropping;
    inFrameNext = inFrame;
    fBeatsNext  = fBeats;
    wrEn        = 1'b0;
    wrAddr      = wrPtr[AW-1:0];
    wrEntry     = '0;
    if (inErr) begin
      if (inFrame && !dropping) begin
        if (live) begin
          // released frame: close it with an empty aborted end beat
          wrEn      = 1'b1;
          wrEntry   = '{data: '0, eof: 1'b1, len: 3'd0, abort: 1'b1};
          wrNext    = wrPtr + PW'(1);
          pubNext   = wrPtr + PW'(1);
          startNext = wrPtr + PW'(1);
        end else begin
          wrNext = startPtr;  // discard unreleased beats
        end
      end
      inFrameNext = 1'b0;
      liveNext    = 1'b0;
      dropNext    = 1'b0;
      fBeatsNext  = '0;
    end else if (inVld) begin
      inFrameNext = !inEof;
      if (effDrop) begin
        dropNext = !inEof;
      end else if (nearFull) begin
        if (effLive) begin
          wrEn      = 1'b1;
          wrEntry   = '{data: '0, eof: 1'b1, len: 3'd0, abort: 1'b1};
          wrNext    = wrPtr + PW'(1);
          pubNext   = wrPtr + PW'(1);
          startNext = wrPtr + PW'(1);
        end else begin
          wrNext    = effStart;
          startNext = effStart;
        end
        liveNext   = 1'b0;
        dropNext   = !inEof;
        fBeatsNext = '0;
      end else if (STRIP && inEof && !inSof && (inLen < 3'd4)) begin
        // last kept byte lies in the previous beat: retag it as the end
        wrEn        = 1'b1;
        wrAddr      = prevIdx;
        wrEntry     = mem[prevIdx];
        wrEntry.eof = 1'b1;
        wrEntry.len = inLen + 3'd4;
        pubNext     = wrPtr;
        startNext   = wrPtr;
        liveNext    = 1'b0;
        dropNext    = 1'b0;
        fBeatsNext  = '0;
      end else begin
        wrEn     = 1'b1;
        wrEntry  = '{data: inData, eof: inEof,
                     len: inEof ? (STRIP ? inLen + 3'd4 : inLen) : 3'd0,
                     abort: 1'b0};
        wrNext   = wrPtr + PW'(1);
        dropNext = 1'b0;
        if (inEof) begin
          pubNext    = wrPtr + PW'(1);
          startNext  = wrPtr + PW'(1);
          liveNext   = 1'b0;
          fBeatsNext = '0;
        end else begin
          startNext  = effStart;
          fBeatsNext = beatsInc;
          liveNext   = goLive;
          // a stripping input keeps the newest beat private: its tag may change
          if (goLive) pubNext = STRIP ? wrPtr : wrPtr + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      startPtr <= '0;
      pubPtr   <= '0;
      rdPtr    <= '0;
      live     <= 1'b0;
      dropping <= 1'b0;
      inFrame  <= 1'b0;
      fBeats   <= '0;
    end else begin
      wrPtr    <= wrNext;
      startPtr <= startNext;
      pubPtr   <= pubNext;
      live     <= liveNext;
      dropping <= dropNext;
      inFrame  <= inFrameNext;
      fBeats   <= fBeatsNext;
      if (pop) rdPtr <= rdPtr + PW'(1);
    end
  end

  assign avail = pubPtr != rdPtr;
  assign head  = mem[rdPtr[AW-1:0]];

  // R10: storage never holds more beats than it has entries
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    count <= PW'(DEPTH_F));
  // R2: the reader only takes released beats
  p_pop_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> avail);
  // R9: released beats always lie inside stored ones
  p_pub_inside_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pubPtr - rdPtr) <= count);

endmodule

// File: rtl/dfm_ctrl.sv
module dfm_ctrl
  import dfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] ready,
  input  logic       xfer,
  input  logic       xferEof,
  output dfm_ctl_t   ctl
);
  logic busy, sel, first, lastSel;
  logic pick;

  assign pick = (ready == 2'b11) ? !lastSel : ready[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      sel     <= 1'b0;
      first   <= 1'b0;
      lastSel <= 1'b1;
    end else if (!busy) begin
      if (ready != 2'b00) begin
        busy  <= 1'b1;
        sel   <= pick;
        first <= 1'b1;
      end
    end else if (xfer) begin
      first <= 1'b0;
      if (xferEof) begin
        busy    <= 1'b0;
        lastSel <= sel;
      end
    end
  end

  assign ctl = '{busy: busy, sel: sel, first: first};

  // R3: the selected input holds for the whole frame
  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(xfer && xferEof) |=> busy && $stable(sel));
  // R3: with both inputs ready, the other input goes next
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy && ready == 2'b11 |=> sel != lastSel);

endmodule

// File: rtl/dfm_outpath.sv
module dfm_outpath
  import dfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dfm_ctl_t         ctl,
  input  dfm_entry_t [1:0] heads,
  input  logic [1:0]       avail,
  input  logic             outAck,
  output logic [63:0]      outData,
  output logic             outSof,
  output logic             outEof,
  output logic [2:0]       outLen,
  output logic             outErr,
  output logic             outVld,
  output logic [1:0]       pop,
  output logic             xfer,
  output logic             xferEof
);
  dfm_entry_t h;

  assign h       = heads[ctl.sel];
  assign outVld  = ctl.busy && avail[ctl.sel];
  assign outData = h.data;
  assign outSof  = outVld && ctl.first;
  assign outEof  = outVld && h.eof;
  assign outLen  = outEof ? h.len : 3'd0;
  assign outErr  = outEof && h.abort;
  assign xfer    = outVld && outAck;
  assign xferEof = xfer && h.eof;
  assign pop     = xfer ? (ctl.sel ? 2'b10 : 2'b01) : 2'b00;

  // R4: an idle cycle follows every transferred end beat
  p_gap_after_eof_r4: assert property (@(posedge clk) disable iff (!rstN)
    outVld && outAck && outEof |=> !outVld);
  // R5: a stalled beat holds
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    outVld && !outAck |=> outVld && $stable(outData) && $stable(outSof)
                          && $stable(outEof) && $stable(outLen));
  // R5: valid stays up through a frame
  p_valid_run_r5: assert property (@(posedge clk) disable iff (!rstN)
    outVld && !(outAck && outEof) |=> outVld);
  // R2: start flag on one beat only
  p_sof_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    outSof && outAck |=> !outSof);

endmodule

// File: rtl/dual_frame_mux.sv
module dual_frame_mux
  import dfm_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int IN0_DELAY  = 0,
  parameter int IN1_DELAY  = 2,
  parameter bit STRIP_FCS0 = 1'b0,
  parameter bit STRIP_FCS1 = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [63:0] in0Data,
  input  logic        in0Sof,
  input  logic        in0Eof,
  input  logic [2:0]  in0Len,
  input  logic        in0Vld,
  input  logic        in0Err,
  input  logic [63:0] in1Data,
  input  logic        in1Sof,
  input  logic        in1Eof,
  input  logic [2:0]  in1Len,
  input  logic        in1Vld,
  input  logic        in1Err,
  output logic [63:0] outData,
  output logic        outSof,
  output logic        outEof,
  output logic [2:0]  outLen,
  output logic        outErr,
  output logic        outVld,
  input  logic        outAck
);
  localparam int FIFO_DEPTH = DEPTH / 2;

  logic [63:0]      inDataA [2];
  logic [2:0]       inLenA  [2];
  logic [1:0]       inSofA, inEofA, inVldA, inErrA;
  dfm_entry_t [1:0] heads;
  logic [1:0]       avail, pop;
  logic             xfer, xferEof;
  dfm_ctl_t         ctl;

  assign inDataA[0] = in0Data;
  assign inDataA[1] = in1Data;
  assign inLenA[0]  = in0Len;
  assign inLenA[1]  = in1Len;
  assign inSofA     = {in1Sof, in0Sof};
  assign inEofA     = {in1Eof, in0Eof};
  assign inVldA     = {in1Vld, in0Vld};
  assign inErrA     = {in1Err, in0Err};

  for (genvar g = 0; g < 2; g++) begin : g_in
    localparam int GDELAY = (g == 0) ? IN0_DELAY : IN1_DELAY;
    localparam bit GSTRIP = (g == 0) ? STRIP_FCS0 : STRIP_FCS1;
    dfm_infifo #(.DEPTH_F(FIFO_DEPTH), .DELAY(GDELAY), .STRIP(GSTRIP)) fifo_i (
      .clk(clk), .rstN(rstN),
      .inData(inDataA[g]), .inSof(inSofA[g]), .inEof(inEofA[g]),
      .inLen(inLenA[g]), .inVld(inVldA[g]), .inErr(inErrA[g]),
      .pop(pop[g]), .avail(avail[g]), .head(heads[g])
    );
  end

  dfm_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ready(avail),
    .xfer(xfer), .xferEof(xferEof), .ctl(ctl)
  );

  dfm_outpath out_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .heads(heads), .avail(avail),
    .outAck(outAck), .outData(outData), .outSof(outSof), .outEof(outEof),
    .outLen(outLen), .outErr(outErr), .outVld(outVld), .pop(pop),
    .xfer(xfer), .xferEof(xferEof)
  );

  // R1: nothing is offered straight after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    !rstN |=> !outVld);

endmodule

// File: tb/dual_frame_mux_tb_top.sv
module dual_frame_mux_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] inData [2];
  logic        inSof  [2];
  logic        inEof  [2];
  logic [2:0]  inLen  [2];
  logic        inVld  [2];
  logic        inErr  [2];
  logic [63:0] outData;
  logic        outSof, outEof, outErr, outVld;
  logic [2:0]  outLen;
  logic        outAck = 1'b1;

  dual_frame_mux dut_i (
    .clk(clk), .rstN(rstN),
    .in0Data(inData[0]), .in0Sof(inSof[0]), .in0Eof(inEof[0]),
    .in0Len(inLen[0]), .in0Vld(inVld[0]), .in0Err(inErr[0]),
    .in1Data(inData[1]), .in1Sof(inSof[1]), .in1Eof(inEof[1]),
    .in1Len(inLen[1]), .in1Vld(inVld[1]), .in1Err(inErr[1]),
    .outData(outData), .outSof(outSof), .outEof(outEof), .outLen(outLen),
    .outErr(outErr), .outVld(outVld), .outAck(outAck)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nCap = 0;
  int gapBad = 0;
  int lastEofCyc = -10;
  int eofCyc [2];
  logic [63:0] capData [256];
  logic        capSof  [256];
  logic        capEof  [256];
  logic        capErr  [256];
  logic [2:0]  capLen  [256];
  int          capCyc  [256];

  always @(negedge clk) begin
    cyc++;
    if (outVld && outAck) begin
      if (nCap < 256) begin
        capData[nCap] = outData;
        capSof[nCap]  = outSof;
        capEof[nCap]  = outEof;
        capErr[nCap]  = outErr;
        capLen[nCap]  = outLen;
        capCyc[nCap]  = cyc;
      end
      if (outSof && lastEofCyc == cyc - 1) gapBad++;
      if (outEof) lastEofCyc = cyc;
      nCap++;
    end
  end

  function automatic logic [63:0] beatVal(int p, int tag, int i);
    return {8'(p), 8'(tag), 16'hC0DE, 32'(i)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic driveFrame(int p, int tag, int n, int lastLen, int errAfter);
    int nb = (errAfter >= 0) ? errAfter : n;
    for (int i = 0; i < nb; i++) begin
      inData[p] = beatVal(p, tag, i);
      inSof[p]  = (i == 0);
      inEof[p]  = (errAfter < 0) && (i == n - 1);
      inLen[p]  = inEof[p] ? 3'(lastLen) : 3'd0;
      inVld[p]  = 1'b1;
      @(posedge clk);
      if (inEof[p]) eofCyc[p] = cyc;
      #1;
    end
    inVld[p] = 1'b0; inSof[p] = 1'b0; inEof[p] = 1'b0; inLen[p] = 3'd0;
    if (errAfter >= 0) begin
      inErr[p] = 1'b1;
      @(posedge clk); #1;
      inErr[p] = 1'b0;
    end
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (30) @(posedge clk);
    #1;
  endtask

  task automatic checkFrame(int base, int p, int tag, int n, int lIn, bit strip, string req);
    int outN, outL;
    if (!strip) begin outN = n; outL = lIn; end
    else if (lIn >= 4) begin outN = n; outL = lIn - 4; end
    else begin outN = n - 1; outL = lIn + 4; end
    for (int i = 0; i < outN; i++) begin
      int k = base + i;
      chk(capData[k] == beatVal(p, tag, i), req, "data", capData[k], beatVal(p, tag, i));
      chk(capSof[k] == (i == 0), req, "sof", longint'(capSof[k]), longint'(i == 0));
      chk(capEof[k] == (i == outN - 1), req, "eof", longint'(capEof[k]), longint'(i == outN - 1));
    end
    chk(capLen[base + outN - 1] == 3'(outL), req, "len", capLen[base + outN - 1], outL);
    chk(capErr[base + outN - 1] == 1'b0, req, "err", longint'(capErr[base + outN - 1]), 0);
  endtask

  task automatic testReset();
    chk(outVld == 1'b0, "R1", "valid during reset", longint'(outVld), 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    chk(outVld == 1'b0, "R1", "valid after reset", longint'(outVld), 0);
  endtask

  task automatic testPassThrough();
    nCap = 0;
    driveFrame(0, 8'h11, 4, 5, -1);
    settle();
    chk(nCap == 4, "R2", "beat count", nCap, 4);
    checkFrame(0, 0, 8'h11, 4, 5, 1'b0, "R2");
    chk(capCyc[0] >= eofCyc[0] + 2, "R6", "store-and-forward start", capCyc[0], eofCyc[0] + 2);
    nCap = 0;
    driveFrame(0, 8'h12, 2, 0, -1);
    settle();
    chk(nCap == 2, "R2", "empty end beat count", nCap, 2);
    checkFrame(0, 0, 8'h12, 2, 0, 1'b0, "R2");
  endtask

  task automatic testCutThrough();
    nCap = 0;
    driveFrame(1, 8'h21, 6, 0, -1);
    settle();
    chk(nCap == 5, "R8", "beat count len0", nCap, 5);
    checkFrame(0, 1, 8'h21, 6, 0, 1'b1, "R8");
    chk(capCyc[0] < eofCyc[1], "R6", "cut-through start before input end", capCyc[0], eofCyc[1]);
  endtask

  task automatic testStripSame();
    nCap = 0;
    driveFrame(1, 8'h31, 4, 6, -1);
    settle();
    chk(nCap == 4, "R7", "beat count len6", nCap, 4);
    checkFrame(0, 1, 8'h31, 4, 6, 1'b1, "R7");
    nCap = 0;
    driveFrame(1, 8'h32, 3, 4, -1);
    settle();
    chk(nCap == 3, "R7", "beat count len4", nCap, 3);
    checkFrame(0, 1, 8'h32, 3, 4, 1'b1, "R7");
  endtask

  task automatic testStripBack();
    nCap = 0;
    driveFrame(1, 8'h41, 3, 2, -1);
    settle();
    chk(nCap == 2, "R8", "beat count len2", nCap, 2);
    checkFrame(0, 1, 8'h41, 3, 2, 1'b1, "R8");
  endtask

  task automatic testArbitration();
    logic [63:0] held;
    nCap = 0;
    outAck = 1'b0;
    fork
      begin driveFrame(0, 8'h51, 3, 3, -1); driveFrame(0, 8'h52, 3, 3, -1); end
      begin driveFrame(1, 8'h53, 3, 6, -1); driveFrame(1, 8'h54, 3, 6, -1); end
    join
    @(negedge clk);
    held = outData;
    chk(outVld == 1'b1 && outSof == 1'b1, "R5", "valid while stalled", longint'(outVld), 1);
    repeat (3) @(negedge clk);
    chk(outData == held && outVld && outSof, "R5", "held data", outData, held);
    chk(nCap == 0, "R5", "no transfer without ack", nCap, 0);
    @(posedge clk); #1 outAck = 1'b1;
    settle();
    chk(nCap == 12, "R3", "beat count", nCap, 12);
    checkFrame(0, 1, 8'h53, 3, 6, 1'b1, "R3");
    checkFrame(3, 0, 8'h51, 3, 3, 1'b0, "R3");
    checkFrame(6, 1, 8'h54, 3, 6, 1'b1, "R3");
    checkFrame(9, 0, 8'h52, 3, 3, 1'b0, "R3");
  endtask

  task automatic testDropErr();
    nCap = 0;
    driveFrame(0, 8'h61, 4, 0, 2);
    driveFrame(1, 8'h62, 4, 0, 1);
    driveFrame(0, 8'h63, 2, 7, -1);
    settle();
    chk(nCap == 2, "R9", "only good frame", nCap, 2);
    checkFrame(0, 0, 8'h63, 2, 7, 1'b0, "R9");
  endtask

  task automatic testOverflow();
    nCap = 0;
    driveFrame(0, 8'h71, 20, 3, -1);
    driveFrame(0, 8'h72, 3, 1, -1);
    settle();
    chk(nCap == 3, "R10", "overflowed frame dropped", nCap, 3);
    checkFrame(0, 0, 8'h72, 3, 1, 1'b0, "R10");
  endtask

  task automatic testLateAbort();
    nCap = 0;
    driveFrame(1, 8'h81, 8, 0, 5);
    settle();
    chk(nCap == 6, "R11", "beat count", nCap, 6);
    for (int i = 0; i < 5; i++) begin
      chk(capData[i] == beatVal(1, 8'h81, i), "R11", "data", capData[i], beatVal(1, 8'h81, i));
      chk(capEof[i] == 1'b0 && capErr[i] == 1'b0, "R11", "early flags", longint'(capEof[i]), 0);
    end
    chk(capEof[5] && capErr[5], "R11", "closing beat flags", longint'(capErr[5]), 1);
    chk(capLen[5] == 3'd0, "R11", "closing len", capLen[5], 0);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      inData[p] = '0; inSof[p] = 1'b0; inEof[p] = 1'b0;
      inLen[p] = '0; inVld[p] = 1'b0; inErr[p] = 1'b0; eofCyc[p] = 0;
    end
    testReset();
    testPassThrough();
    testCutThrough();
    testStripSame();
    testStripBack();
    testArbitration();
    testDropErr();
    testOverflow();
    testLateAbort();
    chk(gapBad == 0, "R4", "start right after end", gapBad, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule